// File: doc/BRIEF.md
# AXI ID-Filtered Traffic Event Generator

This block snoops one AXI port and turns selected handshakes into single-cycle event pulses for a bank of performance counters. It watches three channels: read-address, write-address and read-data. Each accepted handshake on a channel can raise that channel's pulse, but only when the handshake's ID passes a programmable ID and mask comparison and the event is enabled. The block sees only the valid, ready and ID signals. It never touches the data path, and the counting happens downstream.

Software sets up the filter through two 32-bit registers on a simple write and read-back register bus. The filter register at offset 0x00 holds three event enables and the ID mask. The match register at offset 0x04 holds the ID to compare against. One shared ID and mask serve all three events. A typical use is to measure read transactions, write transactions and read beats issued by one master, or by a group of masters.

Top module: `axi_idflt_evgen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all three event outputs are 0. Reset also clears both registers, so they read back as 0.
- R2: A write to offset 0x00 sets the filter register. Bit 31 enables the read-transaction event, bit 30 the write-transaction event and bit 29 the read-beat event. Bits 17:0 hold the ID mask. A read of 0x00 returns these fields, with every other bit 0.
- R3: A write to offset 0x04 stores bits 17:0 as the match ID. A read of 0x04 returns the match ID in bits 17:0, with every other bit 0.
- R4: A write to any other offset changes neither register. A read of any other offset returns 0.
- R5: An ID matches when ((id XOR match_id) AND mask) == 0. Mask bits set to 1 are compared, and mask bits set to 0 are ignored. A mask of 0 matches every ID.
- R6: `ev_rd_txn` is 1 exactly in the cycle after a read-address handshake (`ar_valid` and `ar_ready` both high) whose `ar_id` matches.
- R7: `ev_wr_txn` is 1 exactly in the cycle after a write-address handshake whose `aw_id` matches.
- R8: `ev_rd_beat` is 1 in the cycle after every read-data handshake whose `r_id` matches. Back-to-back beats give back-to-back pulses.
- R9: An event whose enable bit is 0 gives no pulse, whatever the traffic.
- R10: Valid without ready, or ready without valid, gives no pulse.
- R11: A handshake in the same cycle as a register write is judged with the configuration from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| ar_valid | input | 1 | Read-address valid |
| ar_ready | input | 1 | Read-address ready |
| ar_id | input | ID_W | Read-address ID |
| aw_valid | input | 1 | Write-address valid |
| aw_ready | input | 1 | Write-address ready |
| aw_id | input | ID_W | Write-address ID |
| r_valid | input | 1 | Read-data valid |
| r_ready | input | 1 | Read-data ready |
| r_id | input | ID_W | Read-data ID |
| ev_rd_txn | output | 1 | Filtered read-transaction pulse |
| ev_wr_txn | output | 1 | Filtered write-transaction pulse |
| ev_rd_beat | output | 1 | Filtered read-beat pulse |

## Verification
The assertions assume the handshake and ID inputs are known, two-valued signals that change only between clock edges. They treat every cycle in which valid and ready are both high as one accepted handshake, without relying on AXI's rule that valid stays high until ready. The stimulus drives every input on the falling edge and holds it through the next rising edge. It also produces cases that AXI itself would forbid, such as valid dropping without ready, to show that only the combination of valid and ready counts. IDs stay within 18 bits, and register writes use only the two defined offsets plus one unused offset.

// File: rtl/idflt_pkg.sv
package idflt_pkg;
  localparam int NUM_EV     = 3;
  localparam int EN_TOP_BIT = 31;
  localparam logic [7:0] OFS_FILTER = 8'h00;
  localparam logic [7:0] OFS_MATCH  = 8'h04;
  typedef enum int {EV_RD_TXN = 0, EV_WR_TXN = 1, EV_RD_BEAT = 2} ev_e;
endpackage

// File: rtl/idflt_cfg_regs.sv
module idflt_cfg_regs
  import idflt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NUM_EV-1:0] en_vec,
  output logic [ID_W-1:0]   id_mask,
  output logic [ID_W-1:0]   id_match
);
  localparam logic [ADDR_W-1:0] A_FILTER = OFS_FILTER[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_MATCH  = OFS_MATCH[ADDR_W-1:0];

  logic [31:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_vec   <= '0;
      id_mask  <= '0;
      id_match <= '0;
    end else if (wr_en) begin
      if (addr == A_FILTER) begin
        for (int i = 0; i < NUM_EV; i++) en_vec[i] <= wdata[EN_TOP_BIT-i];
        id_mask <= wdata[ID_W-1:0];
      end else if (addr == A_MATCH) begin
        id_match <= wdata[ID_W-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == A_FILTER) begin
      for (int i = 0; i < NUM_EV; i++) rd_next[EN_TOP_BIT-i] = en_vec[i];
      rd_next[ID_W-1:0] = id_mask;
    end else if (addr == A_MATCH) begin
      rd_next[ID_W-1:0] = id_match;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/idflt_match_chan.sv
module idflt_match_chan #(
  parameter int ID_W = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic            ready,
  input  logic [ID_W-1:0] id,
  input  logic [ID_W-1:0] cfg_id,
  input  logic [ID_W-1:0] cfg_mask,
  input  logic            enable,
  output logic            pulse
);
  logic id_hit;
  logic fire;

  assign id_hit = ~|((id ^ cfg_id) & cfg_mask);
  assign fire   = enable & valid & ready & id_hit;

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= fire;
  end
endmodule

// File: rtl/axi_idflt_evgen.sv
module axi_idflt_evgen
  import idflt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic [ID_W-1:0]   r_id,
  output logic              ev_rd_txn,
  output logic              ev_wr_txn,
  output logic              ev_rd_beat
);
  logic [NUM_EV-1:0] en_vec;
  logic [ID_W-1:0]   cfg_mask;
  logic [ID_W-1:0]   cfg_id;
  logic [NUM_EV-1:0] hs_valid;
  logic [NUM_EV-1:0] hs_ready;
  logic [ID_W-1:0]   hs_id [NUM_EV];
  logic [NUM_EV-1:0] ev_vec;

  idflt_cfg_regs #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .en_vec(en_vec), .id_mask(cfg_mask), .id_match(cfg_id)
  );

  assign hs_valid = {r_valid, aw_valid, ar_valid};
  assign hs_ready = {r_ready, aw_ready, ar_ready};
  assign hs_id[EV_RD_TXN]  = ar_id;
  assign hs_id[EV_WR_TXN]  = aw_id;
  assign hs_id[EV_RD_BEAT] = r_id;

  for (genvar c = 0; c < NUM_EV; c++) begin : g_chan
    idflt_match_chan #(.ID_W(ID_W)) u_chan (
      .clk(clk), .rst(rst),
      .valid(hs_valid[c]), .ready(hs_ready[c]), .id(hs_id[c]),
      .cfg_id(cfg_id), .cfg_mask(cfg_mask), .enable(en_vec[c]),
      .pulse(ev_vec[c])
    );
  end

  assign ev_rd_txn  = ev_vec[EV_RD_TXN];
  assign ev_wr_txn  = ev_vec[EV_WR_TXN];
  assign ev_rd_beat = ev_vec[EV_RD_BEAT];
endmodule

// File: rtl/idflt_chk.sv
module idflt_chk #(
  parameter int ID_W = 18
) (
  input logic            clk,
  input logic            rst,
  input logic            ar_valid,
  input logic            ar_ready,
  input logic [ID_W-1:0] ar_id,
  input logic            aw_valid,
  input logic            aw_ready,
  input logic [ID_W-1:0] aw_id,
  input logic            r_valid,
  input logic            r_ready,
  input logic [ID_W-1:0] r_id,
  input logic [2:0]      en_vec,
  input logic [ID_W-1:0] cfg_mask,
  input logic [ID_W-1:0] cfg_id,
  input logic            ev_rd_txn,
  input logic            ev_wr_txn,
  input logic            ev_rd_beat
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!ev_rd_txn && !ev_wr_txn && !ev_rd_beat));

  a_r6_rd_needs_hs: assert property (@(posedge clk) disable iff (rst)
    ev_rd_txn |-> $past(ar_valid && ar_ready));
  a_r7_wr_needs_hs: assert property (@(posedge clk) disable iff (rst)
    ev_wr_txn |-> $past(aw_valid && aw_ready));
  a_r8_beat_needs_hs: assert property (@(posedge clk) disable iff (rst)
    ev_rd_beat |-> $past(r_valid && r_ready));

  a_r5_beat_id_ok: assert property (@(posedge clk) disable iff (rst)
    ev_rd_beat |-> $past(((r_id ^ cfg_id) & cfg_mask) == '0));
  a_r5_rd_id_ok: assert property (@(posedge clk) disable iff (rst)
    ev_rd_txn |-> $past(((ar_id ^ cfg_id) & cfg_mask) == '0));

  a_r6_rd_fires: assert property (@(posedge clk) disable iff (rst)
    (ar_valid && ar_ready && en_vec[0] && (((ar_id ^ cfg_id) & cfg_mask) == '0))
    |=> ev_rd_txn);
  a_r7_wr_fires: assert property (@(posedge clk) disable iff (rst)
    (aw_valid && aw_ready && en_vec[1] && (((aw_id ^ cfg_id) & cfg_mask) == '0))
    |=> ev_wr_txn);

  a_r9_rd_gated: assert property (@(posedge clk) disable iff (rst)
    !en_vec[0] |=> !ev_rd_txn);
  a_r9_wr_gated: assert property (@(posedge clk) disable iff (rst)
    !en_vec[1] |=> !ev_wr_txn);
  a_r9_beat_gated: assert property (@(posedge clk) disable iff (rst)
    !en_vec[2] |=> !ev_rd_beat);
endmodule

bind axi_idflt_evgen idflt_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst),
  .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
  .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
  .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
  .en_vec(en_vec), .cfg_mask(cfg_mask), .cfg_id(cfg_id),
  .ev_rd_txn(ev_rd_txn), .ev_wr_txn(ev_wr_txn), .ev_rd_beat(ev_rd_beat)
);

// File: tb/sim_axi_idflt_evgen.sv
module sim_axi_idflt_evgen;
  logic        clk = 0;
  logic        rst = 1;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ar_valid = 0, ar_ready = 0, aw_valid = 0, aw_ready = 0;
  logic        r_valid = 0, r_ready = 0;
  logic [17:0] ar_id = '0, aw_id = '0, r_id = '0;
  logic        ev_rd_txn, ev_wr_txn, ev_rd_beat;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  logic [2:0]  m_en = '0;
  logic [17:0] m_mask = '0;
  logic [17:0] m_id = '0;

  always #10 clk = ~clk;

  axi_idflt_evgen u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
    .ev_rd_txn(ev_rd_txn), .ev_wr_txn(ev_wr_txn), .ev_rd_beat(ev_rd_beat)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, pushes the expected pulses for the next cycle
  task automatic step(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                      input logic [2:0] v, input logic [2:0] r,
                      input logic [17:0] i_ar, input logic [17:0] i_aw, input logic [17:0] i_r,
                      input string tag);
    item_t it;
    logic [17:0] ids [3];
    @(negedge clk);
    reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    ar_valid = v[0]; ar_ready = r[0]; ar_id = i_ar;
    aw_valid = v[1]; aw_ready = r[1]; aw_id = i_aw;
    r_valid  = v[2]; r_ready  = r[2]; r_id  = i_r;
    ids[0] = i_ar; ids[1] = i_aw; ids[2] = i_r;
    for (int c = 0; c < 3; c++)
      it.exp[c] = m_en[c] & v[c] & r[c] & (((ids[c] ^ m_id) & m_mask) == 18'h0);
    it.tag = tag;
    sb.push_back(it);
    if (wr && addr == 8'h00) begin
      m_en = {wd[29], wd[30], wd[31]};
      m_mask = wd[17:0];
    end else if (wr && addr == 8'h04) begin
      m_id = wd[17:0];
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1, a, d, 3'b000, 3'b000, '0, '0, '0, tag);
  endtask

  task automatic traf(input logic [2:0] v, input logic [2:0] r,
                      input logic [17:0] i_ar, input logic [17:0] i_aw, input logic [17:0] i_r,
                      input string tag);
    step(0, 8'h00, '0, v, r, i_ar, i_aw, i_r, tag);
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
    step(0, a, '0, 3'b000, 3'b000, '0, '0, '0, tag);
    @(posedge clk); #1;
    check(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  // monitor: compares outputs against queued expectations
  always begin
    @(posedge clk); #1;
    if (sb.size() > 0) begin
      item_t it;
      logic [2:0] got;
      it = sb.pop_front();
      got = {ev_rd_beat, ev_wr_txn, ev_rd_txn};
      check(got === it.exp, it.tag, {29'h0, got}, {29'h0, it.exp});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({ev_rd_beat, ev_wr_txn, ev_rd_txn} === 3'b000, "R1 pulses in reset", {29'h0, ev_rd_beat, ev_wr_txn, ev_rd_txn}, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    check({ev_rd_beat, ev_wr_txn, ev_rd_txn} === 3'b000, "R1 pulses after reset", {29'h0, ev_rd_beat, ev_wr_txn, ev_rd_txn}, 0);
    check(reg_rdata === 32'h0, "R1 filter reg after reset", reg_rdata, 0);
    rd_check(8'h04, 32'h0, "R1 match reg after reset");

    // R9 traffic before any enable: nothing fires
    traf(3'b111, 3'b111, 18'h0, 18'h0, 18'h0, "R9 all disabled");

    // R2 R3 programming and readback
    wreg(8'h00, 32'hE003_FFFF, "R2 write");
    wreg(8'h04, 32'hFFFD_2345, "R3 write");
    rd_check(8'h00, 32'hE003_FFFF, "R2 readback");
    rd_check(8'h04, 32'h0001_2345, "R3 readback");
    // R4 unused offset
    wreg(8'h08, 32'hFFFF_FFFF, "R4 write unused");
    rd_check(8'h08, 32'h0, "R4 read unused");
    rd_check(8'h00, 32'hE003_FFFF, "R4 filter kept");
    rd_check(8'h04, 32'h0001_2345, "R4 match kept");

    // R6 read transactions, match and mismatch
    traf(3'b001, 3'b001, 18'h12345, 18'h0, 18'h0, "R6 rd match");
    traf(3'b001, 3'b001, 18'h12344, 18'h0, 18'h0, "R6 rd mismatch");
    traf(3'b001, 3'b001, 18'h12345, 18'h0, 18'h0, "R6 rd again");
    traf(3'b000, 3'b000, 18'h12345, 18'h0, 18'h0, "R6 idle");
    // R10 half handshakes
    traf(3'b111, 3'b000, 18'h12345, 18'h12345, 18'h12345, "R10 valid only");
    traf(3'b000, 3'b111, 18'h12345, 18'h12345, 18'h12345, "R10 ready only");
    // R7 write transactions
    traf(3'b010, 3'b010, 18'h0, 18'h12345, 18'h0, "R7 wr match");
    traf(3'b010, 3'b010, 18'h0, 18'h32345, 18'h0, "R7 wr mismatch");
    // R8 back-to-back read beats, last beat included
    for (int b = 0; b < 4; b++)
      traf(3'b100, 3'b100, 18'h0, 18'h0, 18'h12345, "R8 beat burst");
    traf(3'b100, 3'b100, 18'h0, 18'h0, 18'h02345, "R8 beat mismatch");
    traf(3'b111, 3'b111, 18'h12345, 18'h12345, 18'h12345, "R8 all three at once");

    // R5 partial mask: only low 8 bits compared
    wreg(8'h00, 32'hE000_00FF, "R5 mask low byte");
    traf(3'b111, 3'b111, 18'h3FF45, 18'h00045, 18'h2AA45, "R5 upper ignored");
    traf(3'b111, 3'b111, 18'h12346, 18'h12355, 18'h12345, "R5 low compared");
    wreg(8'h00, 32'hE000_0000, "R5 mask zero");
    traf(3'b111, 3'b111, 18'h3FFFF, 18'h00000, 18'h15555, "R5 mask zero all match");

    // R9 enable only the write event
    wreg(8'h00, 32'h4003_FFFF, "R9 wr only");
    traf(3'b111, 3'b111, 18'h12345, 18'h12345, 18'h12345, "R9 only wr fires");
    wreg(8'h00, 32'hA003_FFFF, "R9 rd and beat");
    traf(3'b111, 3'b111, 18'h12345, 18'h12345, 18'h12345, "R9 wr gated");

    // R11 write in same cycle as handshake uses old config
    step(1, 8'h00, 32'h0003_FFFF, 3'b101, 3'b101, 18'h12345, 18'h0, 18'h12345, "R11 old config");
    traf(3'b101, 3'b101, 18'h12345, 18'h0, 18'h12345, "R11 new config");
    step(1, 8'h04, 32'h0000_0001, 3'b000, 3'b000, '0, '0, '0, "R11 id change");
    wreg(8'h00, 32'h8003_FFFF, "R11 rd enable");
    step(1, 8'h04, 32'h0000_0002, 3'b001, 3'b001, 18'h00001, 18'h0, 18'h0, "R11 old id");
    traf(3'b001, 3'b001, 18'h00001, 18'h0, 18'h0, "R11 new id mismatch");
    traf(3'b001, 3'b001, 18'h00002, 18'h0, 18'h0, "R6 new id match");

    traf(3'b000, 3'b000, '0, '0, '0, "R6 final idle");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule